// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block turns two reset causes into one clean reset request for the rest of a chip. The first cause is a digital undervoltage flag from an external supply comparator. The second is an active-low manual reset line, such as a push button. While either cause is active, the reset request is asserted. Once both have cleared, the request stays asserted for a timeout chosen by a 2-bit code, and only then is it released.

Very short low pulses on the manual line are filtered out. The output takes the form of an open-drain pin. An output-enable signal is high while reset is requested, and the data bit is fixed at zero, so the pad pulls the line low only while reset is active. A synchronous active-high power-on clear puts the block into the asserted state. All durations (glitch reject, timeout menu) are set in time units and are converted to clock cycles from the clock-frequency parameter when the design is elaborated.

Top module: `rstgen_top`

## Requirements
- R1: `rst_oe` high means the pin is pulled low (reset requested). `rst_dat` is 0 at all times.
- R2: While `por_clr` is high, `rst_oe` is 1 from the next clock edge. After `por_clr` falls with no other cause active, `rst_oe` falls exactly LIM cycles after the first edge that samples `por_clr` low.
- R3: `rst_oe` is 1 from the first edge that samples `uv_flag` high, and it stays 1 while the flag is high.
- R4: After the last cause clears, `rst_oe` falls exactly LIM cycles after the first edge at which no cause is active. LIM is selected by `tmo_sel`: 0 gives TMO0_US, 1 gives TMO1_US, 2 gives TMO2_US and 3 gives TMO3_US, each multiplied by CLK_MHZ.
- R5: A supply dip during the timeout clears the count. The full LIM is counted again from the point where the dip ends.
- R6: `mr_n` passes through a two-flop synchronizer. A low counts only once it has been sampled low for G consecutive cycles, where G is GLITCH_NS converted to cycles and rounded up. Shorter lows have no effect on `rst_oe`. Lows of MINPULSE_NS or longer always assert reset.
- R7: A qualifying `mr_n` low raises `rst_oe` exactly G+3 edges after `mr_n` falls. This is within 500 ns at the default settings.
- R8: `rst_oe` stays 1 while `mr_n` is low. It falls exactly 4+LIM edges after `mr_n` returns high, provided no other cause is active.
- R9: `tmo_sel` is sampled only when a timeout count begins. Changing it during a count does not alter that count.
- R10: Every assertion lasts at least LIM cycles, even when it is caused by a one-cycle `uv_flag` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_clr | input | 1 | Synchronous power-on clear, active high |
| uv_flag | input | 1 | Supply-below-threshold flag, synchronous to clk |
| mr_n | input | 1 | Manual reset, active low, asynchronous |
| tmo_sel | input | 2 | Timeout selection code |
| rst_oe | output | 1 | Open-drain enable: 1 pulls the reset line low |
| rst_dat | output | 1 | Open-drain data, fixed at 0 |

## Verification
A bad stretch counter or a wrong stored limit shows up at the ports as a release edge on `rst_oe` that comes early or late by some number of cycles. The bench therefore predicts the exact release cycle for every assertion and compares it with the cycle at which the release is seen. It also reports any release that was not predicted. A bad filter count or a synchronizer of the wrong depth moves the assertion edge after a `mr_n` fall, or lets a short pulse through. Either fault is visible within about 30 cycles of the stimulus. A limit latched at the wrong moment appears as one release that uses the old or new duration when it should have used the other.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;

    typedef enum logic [1:0] {
        TMO_SEL0 = 2'd0,
        TMO_SEL1 = 2'd1,
        TMO_SEL2 = 2'd2,
        TMO_SEL3 = 2'd3
    } tmo_code_e;

    function automatic longint us_to_cyc(input longint us, input longint mhz);
        return us * mhz;
    endfunction

    function automatic longint ns_to_cyc_up(input longint ns, input longint mhz);
        return (ns * mhz + 64'sd999) / 64'sd1000;
    endfunction

    function automatic longint max4(input longint a, input longint b,
                                    input longint c, input longint d);
        longint m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/rstgen_sync.sv
module rstgen_sync (
    input  logic clk,
    input  logic clr,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = din;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk) begin
        if (clr) sync_q <= '{s1: 1'b1, s2: 1'b1};
        else     sync_q <= sync_d;
    end

    assign dout = sync_q.s2;
endmodule

// File: rtl/rstgen_mr_filter.sv
module rstgen_mr_filter #(
    parameter int unsigned G_CYC = 25
) (
    input  logic clk,
    input  logic clr,
    input  logic mr_sync_n,
    output logic mr_act
);
    localparam int unsigned CW = $clog2(G_CYC + 1);
    localparam logic [CW-1:0] G_TOP = CW'(G_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } filt_t;

    filt_t filt_d, filt_q;

    always_comb begin
        filt_d = filt_q;
        if (mr_sync_n)               filt_d.cnt = '0;
        else if (filt_q.cnt != G_TOP) filt_d.cnt = filt_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (clr) filt_q <= '{cnt: '0};
        else     filt_q <= filt_d;
    end

    assign mr_act = (filt_q.cnt == G_TOP);

    // R6: a single high sample drops the qualified low on the next edge
    p_high_clears_r6: assert property (@(posedge clk) disable iff (clr)
        mr_sync_n |=> !mr_act);

    // R6: the counter saturates and never passes the reject count
    p_cnt_cap_r6: assert property (@(posedge clk) disable iff (clr)
        filt_q.cnt <= G_TOP);
endmodule

// File: rtl/rstgen_stretch.sv
module rstgen_stretch
    import rstgen_pkg::*;
#(
    parameter int unsigned   CW   = 8,
    parameter logic [CW-1:0] LIM0 = CW'(10),
    parameter logic [CW-1:0] LIM1 = CW'(20),
    parameter logic [CW-1:0] LIM2 = CW'(30),
    parameter logic [CW-1:0] LIM3 = CW'(40)
) (
    input  logic       clk,
    input  logic       clr,
    input  logic       hold,
    input  tmo_code_e  code,
    output logic       rst_req
);
    typedef struct packed {
        logic          rst;
        logic          run;
        logic [CW-1:0] cnt;
        logic [CW-1:0] lim;
    } str_t;

    str_t str_d, str_q;
    logic [CW-1:0] lim_pick;

    always_comb begin
        unique case (code)
            TMO_SEL0: lim_pick = LIM0;
            TMO_SEL1: lim_pick = LIM1;
            TMO_SEL2: lim_pick = LIM2;
            default:  lim_pick = LIM3;
        endcase
    end

    always_comb begin
        str_d = str_q;
        if (hold) begin
            str_d.rst = 1'b1;
            str_d.run = 1'b0;
            str_d.cnt = '0;
        end else if (str_q.rst && !str_q.run) begin
            str_d.run = 1'b1;
            str_d.cnt = CW'(1);
            str_d.lim = lim_pick;
        end else if (str_q.run) begin
            if (str_q.cnt >= str_q.lim) begin
                str_d.rst = 1'b0;
                str_d.run = 1'b0;
                str_d.cnt = '0;
            end else begin
                str_d.cnt = str_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (clr) str_q <= '{rst: 1'b1, run: 1'b0, cnt: '0, lim: LIM0};
        else     str_q <= str_d;
    end

    assign rst_req = str_q.rst;

    // R3: an active cause asserts reset from the next edge
    p_hold_asserts_r3: assert property (@(posedge clk) disable iff (clr)
        hold |=> rst_req);

    // R4: a release only follows a cycle with no active cause
    p_fall_after_quiet_r4: assert property (@(posedge clk) disable iff (clr)
        $fell(rst_req) |-> $past(!hold));

    // R9: the stored limit is frozen while a count runs
    p_lim_frozen_r9: assert property (@(posedge clk) disable iff (clr)
        (str_q.run && $past(str_q.run)) |-> $stable(str_q.lim));
endmodule

// File: rtl/rstgen_top.sv
module rstgen_top
    import rstgen_pkg::*;
#(
    parameter int unsigned CLK_MHZ     = 250,
    parameter int unsigned GLITCH_NS   = 100,
    parameter int unsigned MINPULSE_NS = 1000,
    parameter int unsigned TMO0_US     = 1500,
    parameter int unsigned TMO1_US     = 30000,
    parameter int unsigned TMO2_US     = 210000,
    parameter int unsigned TMO3_US     = 1680000
) (
    input  logic       clk,
    input  logic       por_clr,
    input  logic       uv_flag,
    input  logic       mr_n,
    input  logic [1:0] tmo_sel,
    output logic       rst_oe,
    output logic       rst_dat
);
    localparam longint L0 = us_to_cyc(longint'(TMO0_US), longint'(CLK_MHZ));
    localparam longint L1 = us_to_cyc(longint'(TMO1_US), longint'(CLK_MHZ));
    localparam longint L2 = us_to_cyc(longint'(TMO2_US), longint'(CLK_MHZ));
    localparam longint L3 = us_to_cyc(longint'(TMO3_US), longint'(CLK_MHZ));
    localparam longint LMAX = max4(L0, L1, L2, L3);
    localparam int unsigned CW = $clog2(LMAX + 1);
    localparam int unsigned G_CYC =
        int'(ns_to_cyc_up(longint'(GLITCH_NS), longint'(CLK_MHZ)));
    localparam int unsigned MIN_CYC =
        int'(ns_to_cyc_up(longint'(MINPULSE_NS), longint'(CLK_MHZ)));

    typedef struct packed {
        logic mr_sync_n;
        logic mr_act;
        logic hold;
        logic rst_req;
    } top_sig_t;

    top_sig_t sig;

    initial begin
        if (G_CYC < 1 || G_CYC + 2 > MIN_CYC)
            $error("glitch count must be at least 1 and leave room for the minimum pulse");
    end

    rstgen_sync u_sync (
        .clk  (clk),
        .clr  (por_clr),
        .din  (mr_n),
        .dout (sig.mr_sync_n)
    );

    rstgen_mr_filter #(.G_CYC(G_CYC)) u_filt (
        .clk       (clk),
        .clr       (por_clr),
        .mr_sync_n (sig.mr_sync_n),
        .mr_act    (sig.mr_act)
    );

    assign sig.hold = uv_flag | sig.mr_act;

    rstgen_stretch #(
        .CW   (CW),
        .LIM0 (CW'(L0)),
        .LIM1 (CW'(L1)),
        .LIM2 (CW'(L2)),
        .LIM3 (CW'(L3))
    ) u_str (
        .clk     (clk),
        .clr     (por_clr),
        .hold    (sig.hold),
        .code    (tmo_code_e'(tmo_sel)),
        .rst_req (sig.rst_req)
    );

    assign rst_oe  = sig.rst_req;
    assign rst_dat = 1'b0;
endmodule

// File: tb/tb_rstgen_top.sv
module tb_rstgen_top;
    localparam int G = 25;
    localparam int LIM [4] = '{250, 500, 750, 1000};

    logic clk = 1'b0;
    logic por_clr = 1'b1, uv_flag = 1'b0, mr_n = 1'b1;
    logic [1:0] tmo_sel = 2'd0;
    logic rst_oe, rst_dat;
    int cyc = 0, total = 0, bad = 0;
    int exp_q[$];
    logic prev_oe = 1'b1;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rstgen_top #(
        .CLK_MHZ(250), .GLITCH_NS(100), .MINPULSE_NS(1000),
        .TMO0_US(1), .TMO1_US(2), .TMO2_US(3), .TMO3_US(4)
    ) dut (
        .clk(clk), .por_clr(por_clr), .uv_flag(uv_flag), .mr_n(mr_n),
        .tmo_sel(tmo_sel), .rst_oe(rst_oe), .rst_dat(rst_dat)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: every release edge is popped against the predicted cycle
    always @(negedge clk) begin
        if (prev_oe && !rst_oe) begin
            if (exp_q.size() == 0) chk(1'b0, "R4 unexpected release", cyc, -1);
            else begin
                int e;
                e = exp_q.pop_front();
                chk(cyc == e, "R4 release cycle", cyc, e);
            end
        end
        if (rst_dat !== 1'b0) chk(1'b0, "R1 rst_dat", int'(rst_dat), 0);
        prev_oe <= rst_oe;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hang expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit quiet;
        // R1 R2: reset state
        waitn(3);
        chk(rst_oe == 1'b1, "R2 por asserts", int'(rst_oe), 1);
        chk(rst_dat == 1'b0, "R1 dat low", int'(rst_dat), 0);
        por_clr = 1'b0;
        exp_q.push_back(cyc + 1 + LIM[0]);
        waitn(LIM[0] + 10);
        chk(rst_oe == 1'b0, "R2 released", int'(rst_oe), 0);

        // R3 R4: each timeout code
        for (int k = 0; k < 4; k++) begin
            tmo_sel = 2'(k);
            uv_flag = 1'b1;
            waitn(1);
            chk(rst_oe == 1'b1, "R3 uv asserts", int'(rst_oe), 1);
            waitn(20);
            chk(rst_oe == 1'b1, "R3 uv held", int'(rst_oe), 1);
            uv_flag = 1'b0;
            exp_q.push_back(cyc + 1 + LIM[k]);
            waitn(LIM[k] + 10);
        end

        // R5: dip during the count restarts it
        tmo_sel = 2'd1;
        uv_flag = 1'b1; waitn(5); uv_flag = 1'b0;
        waitn(200);
        uv_flag = 1'b1; waitn(3);
        chk(rst_oe == 1'b1, "R5 still asserted", int'(rst_oe), 1);
        uv_flag = 1'b0;
        exp_q.push_back(cyc + 1 + LIM[1]);
        waitn(LIM[1] + 20);

        // R10: one-cycle uv pulse
        tmo_sel = 2'd0;
        uv_flag = 1'b1; waitn(1); uv_flag = 1'b0;
        chk(rst_oe == 1'b1, "R10 short pulse asserts", int'(rst_oe), 1);
        exp_q.push_back(cyc + 1 + LIM[0]);
        waitn(LIM[0] + 20);

        // R6: low pulses of G-1 cycles and of 1 cycle are rejected
        quiet = 1'b1;
        mr_n = 1'b0; waitn(G - 1); mr_n = 1'b1;
        for (int i = 0; i < 40; i++) begin waitn(1); if (rst_oe) quiet = 1'b0; end
        chk(quiet, "R6 short low ignored", int'(!quiet), 0);
        quiet = 1'b1;
        mr_n = 1'b0; waitn(1); mr_n = 1'b1;
        for (int i = 0; i < 40; i++) begin waitn(1); if (rst_oe) quiet = 1'b0; end
        chk(quiet, "R6 one-cycle low ignored", int'(!quiet), 0);

        // R7 R8 R6: qualifying low, held beyond the minimum pulse
        tmo_sel = 2'd2;
        mr_n = 1'b0;
        waitn(G + 2);
        chk(rst_oe == 1'b0, "R7 not yet asserted", int'(rst_oe), 0);
        waitn(1);
        chk(rst_oe == 1'b1, "R7 asserted at G+3", int'(rst_oe), 1);
        waitn(300);
        chk(rst_oe == 1'b1, "R8 held while low", int'(rst_oe), 1);
        mr_n = 1'b1;
        exp_q.push_back(cyc + 4 + LIM[2]);
        waitn(LIM[2] + 20);

        // R9: code change mid-count keeps the running duration
        tmo_sel = 2'd0;
        uv_flag = 1'b1; waitn(2); uv_flag = 1'b0;
        exp_q.push_back(cyc + 1 + LIM[0]);
        waitn(100);
        tmo_sel = 2'd3;
        waitn(LIM[0]);
        chk(rst_oe == 1'b0, "R9 old duration kept", int'(rst_oe), 0);
        uv_flag = 1'b1; waitn(2); uv_flag = 1'b0;
        exp_q.push_back(cyc + 1 + LIM[3]);
        waitn(LIM[3] + 20);

        // R8: overlapping causes, manual released last
        tmo_sel = 2'd1;
        uv_flag = 1'b1; mr_n = 1'b0;
        waitn(50);
        uv_flag = 1'b0;
        waitn(50);
        chk(rst_oe == 1'b1, "R8 manual still holds", int'(rst_oe), 1);
        mr_n = 1'b1;
        exp_q.push_back(cyc + 4 + LIM[1]);
        waitn(LIM[1] + 20);

        chk(exp_q.size() == 0, "R4 all releases seen", exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule